// File: doc/BRIEF.md
# Paged configuration register file

This block is a byte-wide register file addressed through an 8-bit register address, the width a serial register interface typically delivers per access. Behind that address sits a larger store. It holds four identical, protocol-specific configuration sets and one shared set of common registers.

A page-select register, itself one of the common registers, decides which configuration set the lower half of the address space reaches. The common registers answer at the same addresses whatever page is selected, and they resolve to a single stored copy. The rest of the upper half is reserved.

Accesses to a reserved address change nothing, read as zero and raise a one-cycle error pulse. Accesses arrive as single-cycle read and write strobes. Read data is registered and holds its value between reads.

Top module: `cfgbank_regfile`

## Requirements
- R1: While rst_n is low and after it is released, rd_data, rd_valid and acc_err are 0, the selected page is 0 and every register reads 0x00.
- R2: rd_valid is high in exactly the cycle after a cycle with req_rd high, and rd_data carries the addressed value in that same cycle.
- R3: Addresses 0x00 to 0x7F reach the configuration set of the selected page. A write on one page leaves the same address on the other three pages unchanged.
- R4: Addresses 0xC1 to 0xDF are common registers. A value written while any page is selected reads back unchanged under every page.
- R5: Address 0xC0 is the page-select register. A write sets the page to req_wdata[1:0], and a read returns the page in bits 1:0 with bits 7:2 reading 0.
- R6: Addresses 0x80 to 0xBF and 0xE0 to 0xFF are reserved. Writes to them change no register, and reads from them return 0x00.
- R7: acc_err is high for exactly the one cycle after a read or write strobe to a reserved address, and low after every other cycle.
- R8: When req_rd and req_wr are both high for the same address, the read returns the contents from before that write, and the write takes effect.
- R9: In a cycle after one without req_rd, rd_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_addr | input | 8 | Logical register address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, held between reads |
| rd_valid | output | 1 | High in the cycle rd_data answers a read |
| acc_err | output | 1 | One-cycle pulse after an access to a reserved address |

## Verification
The hardest fault to expose from the ports is aliasing: a page bit that is dropped from the storage index, or a common register that is accidentally banked per page. Either fault still looks correct on any single page. To catch it, the bench fills every configuration set with a pattern that depends on both the page and the address. It writes the common registers under a page other than 0. It then reads all 256 addresses back under each of the four pages, so any wrong mapping shows up as a value from the wrong page. Reserved writes of all-ones come after these fills, and a second full sweep follows them, so any leak of a reserved write into real storage becomes visible.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PAGE_CNT = 4;
  localparam int unsigned CMN_BASE = 'hC0;
  localparam int unsigned CMN_CNT  = 32;

  typedef enum logic [1:0] {
    RGN_CFG  = 2'd0,
    RGN_CMN  = 2'd1,
    RGN_PAGE = 2'd2,
    RGN_RSVD = 2'd3
  } region_e;
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 2,
  parameter int unsigned CMN_BASE  = 'hC0,
  parameter int unsigned CMN_CNT   = 32,
  parameter int unsigned CFG_IDX_W = PAGE_W + ADDR_W - 1,
  parameter int unsigned CMN_IDX_W = $clog2(CMN_CNT)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PAGE_W-1:0]    page,
  output region_e              region,
  output logic [CFG_IDX_W-1:0] cfg_idx,
  output logic [CMN_IDX_W-1:0] cmn_idx
);
  localparam int unsigned CMN_END = CMN_BASE + CMN_CNT;

  logic [ADDR_W:0] addr_ext;
  logic            in_cmn;

  always_comb begin
    addr_ext = {1'b0, addr};
    in_cmn   = (addr_ext > (ADDR_W+1)'(CMN_BASE)) &&
               (addr_ext < (ADDR_W+1)'(CMN_END));
    if (!addr[ADDR_W-1])
      region = RGN_CFG;
    else if (addr_ext == (ADDR_W+1)'(CMN_BASE))
      region = RGN_PAGE;
    else if (in_cmn)
      region = RGN_CMN;
    else
      region = RGN_RSVD;
  end

  // Configuration index: page on top of the lower-half offset.
  assign cfg_idx = {page, addr[ADDR_W-2:0]};
  // Common index: offset from the common window base.
  assign cmn_idx = CMN_IDX_W'(addr - ADDR_W'(CMN_BASE));
endmodule

// File: rtl/cfgbank_pagesel.sv
module cfgbank_pagesel #(
  parameter int unsigned PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] page_d, page_q;

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wr_page;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page = page_q;
endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CFG_DEPTH = 512,
  parameter int unsigned CMN_CNT   = 32,
  parameter int unsigned CFG_IDX_W = $clog2(CFG_DEPTH),
  parameter int unsigned CMN_IDX_W = $clog2(CMN_CNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic                 cmn_we,
  input  logic [CMN_IDX_W-1:0] cmn_idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic [DATA_W-1:0]    cmn_rdata
);
  // Banked configuration sets: one array, page-major.
  logic [DATA_W-1:0] cfg_mem [CFG_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(CFG_DEPTH); i++) cfg_mem[i] <= '0;
    end else if (cfg_we) begin
      cfg_mem[cfg_idx] <= wdata;
    end
  end

  assign cfg_rdata = cfg_mem[cfg_idx];

  // Common registers: a single copy, one enabled register per entry.
  logic [DATA_W-1:0] cmn_arr [CMN_CNT];

  for (genvar g = 0; g < int'(CMN_CNT); g++) begin : g_cmn
    logic              hit;
    logic [DATA_W-1:0] q, d;
    assign hit = cmn_we && (cmn_idx == CMN_IDX_W'(g));
    always_comb begin
      d = q;
      if (hit) d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign cmn_arr[g] = q;
  end

  assign cmn_rdata = cmn_arr[cmn_idx];
endmodule

// File: rtl/cfgbank_regfile.sv
module cfgbank_regfile
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = cfgbank_pkg::ADDR_W,
  parameter int unsigned DATA_W   = cfgbank_pkg::DATA_W,
  parameter int unsigned PAGE_CNT = cfgbank_pkg::PAGE_CNT,
  parameter int unsigned CMN_BASE = cfgbank_pkg::CMN_BASE,
  parameter int unsigned CMN_CNT  = cfgbank_pkg::CMN_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              acc_err
);
  localparam int unsigned PAGE_W    = $clog2(PAGE_CNT);
  localparam int unsigned CFG_IDX_W = PAGE_W + ADDR_W - 1;
  localparam int unsigned CFG_DEPTH = PAGE_CNT << (ADDR_W - 1);
  localparam int unsigned CMN_IDX_W = $clog2(CMN_CNT);

  region_e              region;
  logic [PAGE_W-1:0]    page;
  logic [CFG_IDX_W-1:0] cfg_idx;
  logic [CMN_IDX_W-1:0] cmn_idx;
  logic [DATA_W-1:0]    cfg_rdata, cmn_rdata;
  logic                 cfg_we, cmn_we, page_we;

  cfgbank_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMN_BASE(CMN_BASE),
    .CMN_CNT(CMN_CNT), .CFG_IDX_W(CFG_IDX_W), .CMN_IDX_W(CMN_IDX_W)
  ) u_decode (
    .addr(req_addr), .page(page), .region(region),
    .cfg_idx(cfg_idx), .cmn_idx(cmn_idx)
  );

  assign cfg_we  = req_wr && (region == RGN_CFG);
  assign cmn_we  = req_wr && (region == RGN_CMN);
  assign page_we = req_wr && (region == RGN_PAGE);

  cfgbank_pagesel #(.PAGE_W(PAGE_W)) u_pagesel (
    .clk(clk), .rst_n(rst_n), .wr_en(page_we),
    .wr_page(req_wdata[PAGE_W-1:0]), .page(page)
  );

  cfgbank_store #(
    .DATA_W(DATA_W), .CFG_DEPTH(CFG_DEPTH), .CMN_CNT(CMN_CNT),
    .CFG_IDX_W(CFG_IDX_W), .CMN_IDX_W(CMN_IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cmn_we(cmn_we), .cmn_idx(cmn_idx),
    .wdata(req_wdata),
    .cfg_rdata(cfg_rdata), .cmn_rdata(cmn_rdata)
  );

  // Read selection: contents before any same-cycle write.
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (region)
      RGN_CFG:  rd_mux = cfg_rdata;
      RGN_CMN:  rd_mux = cmn_rdata;
      RGN_PAGE: rd_mux = DATA_W'(page);
      default:  rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rd_data_d, rd_data_q;
  logic              rd_valid_d, rd_valid_q;
  logic              err_d, err_q;

  always_comb begin
    rd_data_d  = rd_data_q;
    if (req_rd) rd_data_d = rd_mux;
    rd_valid_d = req_rd;
    err_d      = (req_rd || req_wr) && (region == RGN_RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
      err_q      <= err_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign acc_err  = err_q;
endmodule

// File: rtl/cfgbank_regfile_chk.sv
module cfgbank_regfile_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CMN_BASE = 'hC0,
  parameter int unsigned CMN_CNT  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_wr,
  input logic              req_rd,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              acc_err
);
  localparam int unsigned CMN_END = CMN_BASE + CMN_CNT;

  logic rsvd_addr, sel_addr;
  always_comb begin
    rsvd_addr = req_addr[ADDR_W-1] &&
                !(({1'b0, req_addr} >= (ADDR_W+1)'(CMN_BASE)) &&
                  ({1'b0, req_addr} <  (ADDR_W+1)'(CMN_END)));
    sel_addr  = ({1'b0, req_addr} == (ADDR_W+1)'(CMN_BASE));
  end

  // R2
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rd_valid);
  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rd_valid);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && rsvd_addr) |=> acc_err);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((req_rd || req_wr) && rsvd_addr) |=> !acc_err);
  // R6
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && rsvd_addr) |=> (rd_data == '0));
  // R5
  page_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && sel_addr) |=> (rd_data[DATA_W-1:2] == '0));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> $stable(rd_data));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0 && !rd_valid && !acc_err));
endmodule

bind cfgbank_regfile cfgbank_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMN_BASE(CMN_BASE), .CMN_CNT(CMN_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
  .req_addr(req_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .acc_err(acc_err)
);

// File: tb/cfgbank_regfile_bench.sv
module cfgbank_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_wr, req_rd;
  logic [7:0] req_addr, req_wdata;
  logic [7:0] rd_data;
  logic       rd_valid, acc_err;

  cfgbank_regfile u_cfgbank_regfile (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] exp_cfg [512];
  logic [7:0] exp_cmn [32];
  int         exp_page;

  task automatic check(input bit ok, input string tag,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_rsvd(input int a);
    return (a >= 'h80 && a < 'hC0) || (a >= 'hE0);
  endfunction

  function automatic string tag_for(input int a);
    if (a < 'h80)  return "R3";
    if (a == 'hC0) return "R5";
    if (is_rsvd(a)) return "R6";
    return "R4";
  endfunction

  function automatic logic [7:0] model_read(input int a);
    if (a < 'h80)   return exp_cfg[exp_page*128 + a];
    if (a == 'hC0)  return 8'(exp_page);
    if (is_rsvd(a)) return 8'h00;
    return exp_cmn[a - 'hC0];
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    if (a < 'h80)        exp_cfg[exp_page*128 + a] = d;
    else if (a == 'hC0)  exp_page = int'(d[1:0]);
    else if (!is_rsvd(a)) exp_cmn[a - 'hC0] = d;
  endtask

  // One access: drive at a falling edge, check at the next falling edge.
  task automatic access(input bit wr, input bit rd, input int a,
                        input logic [7:0] d, input string tag);
    logic [7:0] exp_rd, prev;
    bit exp_err;
    exp_rd  = model_read(a);
    exp_err = (wr || rd) && is_rsvd(a);
    @(negedge clk);
    prev      = rd_data;
    req_wr    = wr;
    req_rd    = rd;
    req_addr  = 8'(a);
    req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    req_rd = 1'b0;
    if (rd) begin
      check(rd_valid === 1'b1, "R2", int'(rd_valid), 1);
      check(rd_data === exp_rd, tag, int'(rd_data), int'(exp_rd));
    end else begin
      check(rd_valid === 1'b0, "R2", int'(rd_valid), 0);
      check(rd_data === prev, "R9", int'(rd_data), int'(prev));
    end
    check(acc_err === exp_err, "R7", int'(acc_err), int'(exp_err));
    if (wr) model_write(a, d);
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 256; a++) access(1'b0, 1'b1, a, 8'h00, tag_for(a));
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_cfg[i] = 8'h00;
    for (int i = 0; i < 32; i++)  exp_cmn[i] = 8'h00;
    exp_page  = 0;
    rst_n     = 1'b0;
    req_wr    = 1'b0;
    req_rd    = 1'b0;
    req_addr  = 8'h00;
    req_wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(rd_data === 8'h00, "R1", int'(rd_data), 0);
    check(rd_valid === 1'b0, "R1", int'(rd_valid), 0);
    check(acc_err === 1'b0, "R1", int'(acc_err), 0);
    rst_n = 1'b1;
    // R1: every address reads zero after reset, page 0
    for (int a = 0; a < 256; a++) access(1'b0, 1'b1, a, 8'h00, "R1");

    // R3: page-dependent patterns in every configuration set
    for (int p = 0; p < 4; p++) begin
      access(1'b1, 1'b0, 'hC0, 8'(p), "R5");
      for (int a = 0; a < 128; a++)
        access(1'b1, 1'b0, a, 8'((p*67 + a*5 + 1) & 'hFF), "R3");
    end
    // R4: common registers written under page 2
    access(1'b1, 1'b0, 'hC0, 8'h02, "R5");
    for (int a = 'hC1; a < 'hE0; a++)
      access(1'b1, 1'b0, a, 8'((a*13 + 7) & 'hFF), "R4");
    // Full read-back under every page
    for (int p = 0; p < 4; p++) begin
      access(1'b1, 1'b0, 'hC0, 8'(p), "R5");
      sweep_reads();
    end

    // R6, R7: reserved writes of all-ones, then re-read under page 1
    for (int a = 'h80; a < 256; a++)
      if (is_rsvd(a)) access(1'b1, 1'b0, a, 8'hFF, "R6");
    access(1'b1, 1'b0, 'hC0, 8'h01, "R5");
    sweep_reads();

    // R5: upper bits of the page write are dropped
    access(1'b1, 1'b0, 'hC0, 8'hFE, "R5");
    access(1'b0, 1'b1, 'hC0, 8'h00, "R5");
    check(rd_data === 8'h02, "R5", int'(rd_data), 2);

    // R8: same-cycle read and write returns old contents
    access(1'b1, 1'b1, 'h05, 8'hA5, "R8");
    access(1'b0, 1'b1, 'h05, 8'h00, "R8");
    check(rd_data === 8'hA5, "R8", int'(rd_data), 'hA5);
    access(1'b1, 1'b1, 'hD3, 8'h3C, "R8");
    access(1'b0, 1'b1, 'hD3, 8'h00, "R8");
    access(1'b1, 1'b1, 'hF0, 8'h77, "R8");

    // R9: idle and write-only cycles hold rd_data
    access(1'b0, 1'b1, 'h10, 8'h00, "R3");
    for (int i = 0; i < 4; i++) access(1'b0, 1'b0, 'h20, 8'h00, "R9");
    access(1'b1, 1'b0, 'h10, 8'h5A, "R9");
    access(1'b1, 1'b0, 'hA0, 8'h5A, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule